// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block sits beside a two-wire bus master and brings a stuck bus back into service. A slave may still be driving the data line low after an aborted transfer, a reset or a brown-out. In that case a request to the sequencer makes it toggle the clock line with dummy pulses while it leaves the data line released. It watches both lines in the high half of every pulse. When it sees the bus released, it produces a Start condition and then returns the lines to the owning master.

Both lines are driven open-drain. The block only ever asserts an enable that pulls a line low. The length of each clock half-period is set by an input and captured when a request is accepted. A hard limit on the number of dummy pulses keeps the recovery bounded. If the slave still holds the bus at the last pulse, a sticky failure flag reports that only a power cycle of that slave can clear it.

Top module: `twi_recover`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `done` and `fail` are all 0.
- R2: An accepted request starts dummy pulses one cycle later. Each pulse pulls SCL low (`scl_oe`=1) for H cycles and then releases it for H cycles, where H is the value of `half_period` and a value of 0 counts as 1. `sda_oe` stays 0 for all dummy pulses.
- R3: Both lines are sampled in the last cycle of each released-SCL half of a pulse. The first such sample that reads `sda_in`=1 ends the dummy pulses.
- R4: No more than 9 dummy pulses (SCL low phases) are issued in one attempt.
- R5: After a release is seen, the block issues a Start by asserting `sda_oe` with SCL released for H cycles. It then pulls both lines low for H cycles. A request that releases on pulse k therefore shows `done` 2·H·(k+1)+1 cycles after the request was sampled.
- R6: `done` is a single-cycle pulse that follows the Start sequence. It is never asserted together with `fail`.
- R7: If the 9th sample does not show a released bus, `fail` goes to 1 in cycle 18·H+1 after the request. Both lines are then released and no Start is issued. `fail` stays 1 until the next accepted request, which clears it in its first cycle.
- R8: `start_recovery` has no effect while an attempt is in progress.
- R9: The bus counts as released only when `scl_in` and `sda_in` are both 1 at the sample. If a slave holds SCL low, the sample is a failed one even when SDA is high.
- R10: `half_period` is captured when a request is accepted. Changing it during an attempt does not alter that attempt's timing.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_recovery | input | 1 | Request to begin a recovery attempt (taken only when idle) |
| half_period | input | HP_W | SCL half-period in clock cycles (0 treated as 1) |
| scl_in | input | 1 | Synchronized level of the SCL line |
| sda_in | input | 1 | Synchronized level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| done | output | 1 | One-cycle pulse: bus recovered and Start issued |
| fail | output | 1 | Sticky: slave did not release within the pulse limit |

## Verification
The bound checker enforces the following on every clock:
- the pulse limit;
- that both lines are free while `fail` is set;
- the single-cycle, exclusive nature of `done`;
- that the Start edge occurs with SCL released, after a sample that saw both lines high.

The exact phase lengths, the total latency to `done` or `fail`, and the point at which pulsing stops can only be shown by the bench. The bench checks these against a slave model that releases SDA after a chosen number of pulses. The same holds for the effect of a slave that holds SCL low, for requests and period changes during an attempt, and for a zero half-period.

// File: rtl/twi_rec_pkg.sv
// Package: shared state encoding for the bus recovery sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package twi_rec_pkg;

    // Sequencer phases, in the order an attempt walks through them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // lines released, waiting for a request
        ST_LOW   = 3'd1,   // dummy pulse, SCL pulled low
        ST_HIGH  = 3'd2,   // dummy pulse, SCL released, sample at end
        ST_START = 3'd3,   // SDA pulled low with SCL released (Start)
        ST_TAIL  = 3'd4    // both pulled low before hand-over
    } rec_state_t;

endpackage

// File: rtl/twi_rec_timer.sv
// Phase timer: counts out one SCL half-period per phase.
// Captures the requested half-period when an attempt is accepted, so later
// changes on the input have no effect. A value of zero is treated as one.
// Assumes load is asserted on the edge that enters each new phase.
module twi_rec_timer #(
    parameter int HP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            load,
    input  logic [HP_W-1:0] half_period,
    output logic            last
);
    logic [HP_W-1:0] hp_q;
    logic [HP_W-1:0] src_w;
    logic [HP_W-1:0] len_w;
    logic [HP_W-1:0] cnt_q;

    // Hold the half-period chosen for the running attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)       hp_q <= '0;
        else if (capture) hp_q <= half_period;
    end

    // Pick the live input on the capture edge, else the held copy; clamp zero.
    always_comb begin
        src_w = capture ? half_period : hp_q;
        len_w = (src_w == '0) ? HP_W'(1) : src_w;
    end

    // Down-counter: len-1 at phase entry, phase ends when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= len_w - HP_W'(1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - HP_W'(1);
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/twi_rec_pulse_cnt.sv
// Pulse counter: counts dummy SCL pulses issued in the current attempt and
// flags when the configured limit has been reached.
// Assumes clear and inc are never asserted together.
module twi_rec_pulse_cnt #(
    parameter int MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_PULSES + 1);

    logic [CW-1:0] cnt_q;

    // Count pulses; saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt_q <= '0;
        else if (clear)                              cnt_q <= '0;
        else if (inc && (cnt_q != CW'(MAX_PULSES)))  cnt_q <= cnt_q + CW'(1);
    end

    assign at_limit = (cnt_q == CW'(MAX_PULSES));
endmodule

// File: rtl/twi_rec_fsm.sv
// Sequencer control: walks dummy pulses, Start and hand-over, and owns the
// done pulse and the sticky fail flag. Line enables decode from the state.
// Assumes scl_in/sda_in are already synchronized to clk.
module twi_rec_fsm
    import twi_rec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_recovery,
    input  logic last,
    input  logic at_limit,
    input  logic scl_in,
    input  logic sda_in,
    output logic capture,
    output logic load,
    output logic cnt_clear,
    output logic cnt_inc,
    output logic scl_oe,
    output logic sda_oe,
    output logic done,
    output logic fail
);
    rec_state_t state_q, state_d;
    logic       line_idle;
    logic       fail_set;
    logic       done_set;

    assign line_idle = scl_in && sda_in;

    // Next-state and control strobes for timer and pulse counter.
    always_comb begin
        state_d   = state_q;
        capture   = 1'b0;
        load      = 1'b0;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        fail_set  = 1'b0;
        done_set  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_recovery) begin
                state_d   = ST_LOW;
                capture   = 1'b1;
                load      = 1'b1;
                cnt_clear = 1'b1;
            end
            ST_LOW: if (last) begin
                state_d = ST_HIGH;
                load    = 1'b1;
                cnt_inc = 1'b1;
            end
            ST_HIGH: if (last) begin
                load = 1'b1;
                if (line_idle)     state_d = ST_START;
                else if (at_limit) begin
                    state_d  = ST_IDLE;
                    fail_set = 1'b1;
                end
                else               state_d = ST_LOW;
            end
            ST_START: if (last) begin
                state_d = ST_TAIL;
                load    = 1'b1;
            end
            ST_TAIL: if (last) begin
                state_d  = ST_IDLE;
                done_set = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Done pulse lasts one cycle after the hand-over phase.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= done_set;
    end

    // Fail is sticky until the next accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)        fail <= 1'b0;
        else if (fail_set) fail <= 1'b1;
        else if (capture)  fail <= 1'b0;
    end

    // Open-drain enables decoded from the phase.
    always_comb begin
        scl_oe = (state_q == ST_LOW)   || (state_q == ST_TAIL);
        sda_oe = (state_q == ST_START) || (state_q == ST_TAIL);
    end
endmodule

// File: rtl/twi_recover.sv
// Top of the two-wire bus recovery sequencer. On request it clocks dummy
// pulses until the bus reads released, issues a Start and pulses done, or
// flags fail once the pulse limit is used up.
// Assumes bus inputs are synchronized upstream and the owning master takes
// the lines in the cycle done is seen.
module twi_recover #(
    parameter int HP_W       = 16,
    parameter int MAX_PULSES = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_recovery,
    input  logic [HP_W-1:0] half_period,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            scl_oe,
    output logic            sda_oe,
    output logic            done,
    output logic            fail
);
    logic capture_w, load_w, clear_w, inc_w, last_w, limit_w;

    twi_rec_timer #(.HP_W(HP_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .capture(capture_w), .load(load_w),
        .half_period(half_period), .last(last_w)
    );

    twi_rec_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) pcnt_i (
        .clk(clk), .rst_n(rst_n), .clear(clear_w), .inc(inc_w),
        .at_limit(limit_w)
    );

    twi_rec_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .start_recovery(start_recovery),
        .last(last_w), .at_limit(limit_w), .scl_in(scl_in), .sda_in(sda_in),
        .capture(capture_w), .load(load_w), .cnt_clear(clear_w),
        .cnt_inc(inc_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .done(done), .fail(fail)
    );
endmodule

// File: rtl/twi_recover_chk.sv
// Checker for the recovery sequencer, bound to every instance of the top.
// Observes ports only; counts dummy pulses with its own counter.
module twi_recover_chk #(
    parameter int MAX_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_in,
    input logic scl_oe,
    input logic sda_oe,
    input logic done,
    input logic fail
);
    localparam int PW = $clog2(MAX_PULSES + 2);

    logic          scl_prev;
    logic [PW-1:0] pulses_q;

    // Count SCL pull-downs made without SDA pulled; clear at attempt end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b0;
            pulses_q <= '0;
        end else begin
            scl_prev <= scl_oe;
            if (done || fail || sda_oe)              pulses_q <= '0;
            else if (scl_oe && !scl_prev && pulses_q != '1) pulses_q <= pulses_q + PW'(1);
        end
    end

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= PW'(MAX_PULSES));                                // R4
    AST_FAIL_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!scl_oe && !sda_oe));                              // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R6
    AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));                                            // R6
    AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_oe);                                  // R5
    AST_START_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_in && sda_in));                  // R9
    AST_DONE_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(scl_oe && sda_oe));                           // R5
endmodule

bind twi_recover twi_recover_chk #(.MAX_PULSES(MAX_PULSES)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .fail(fail)
);

// File: tb/twi_recover_tb_top.sv
module twi_recover_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HP_W       = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_recovery = 1'b0;
    logic [HP_W-1:0] half_period = '0;
    logic            scl_oe, sda_oe, done, fail;
    logic            slave_rel = 1'b0;
    logic            stretch = 1'b0;
    logic            scl_in, sda_in;
    int              checks = 0;
    int              failures = 0;
    bit              finished = 1'b0;

    assign scl_in = !scl_oe && !stretch;
    assign sda_in = !sda_oe && slave_rel;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_recover #(.HP_W(HP_W), .MAX_PULSES(9)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_recovery(start_recovery),
        .half_period(half_period), .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .fail(fail)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected pulse count: slave releases on pulse max(rel,1); held SCL never releases.
    function automatic int exp_pulses(input int rel, input bit str);
        int k = (rel < 1) ? 1 : rel;
        if (str || k > 9) return 9;
        return k;
    endfunction

    function automatic bit exp_ok(input int rel, input bit str);
        return !str && (((rel < 1) ? 1 : rel) <= 9);
    endfunction

    task automatic run_attempt(input int h, input int rel, input bit str, input bit poke);
        int  he   = (h == 0) ? 1 : h;
        int  k    = exp_pulses(rel, str);
        bit  ok   = exp_ok(rel, str);
        int  expi = ok ? 2*he*(k+1)+1 : 18*he+1;
        int  idx = 1, pulses = 0, lowc = 0, stc = 0, tlc = 0, rel_cnt = 0;
        bit  prev = 1'b0, got_done = 1'b0, got_fail = 1'b0;
        half_period = HP_W'(h);
        stretch     = str;
        slave_rel   = (rel <= 0);
        @(negedge clk) start_recovery = 1'b1;
        @(negedge clk) start_recovery = 1'b0;
        chk(fail == 1'b0, "R7", "fail cleared by new request", fail, 0);
        while (idx < 4000) begin
            if (!scl_oe && prev) begin
                rel_cnt++;
                if (rel_cnt >= rel) slave_rel = 1'b1;
            end
            if (scl_oe && !prev && !sda_oe) pulses++;
            if (scl_oe && !sda_oe) lowc++;
            if (sda_oe && !scl_oe) stc++;
            if (sda_oe && scl_oe)  tlc++;
            if (poke && idx == 3) begin
                start_recovery = 1'b1;               // R8 ignored while busy
                half_period    = HP_W'(he + 3);      // R10 no effect mid-attempt
            end
            if (idx == 4) start_recovery = 1'b0;
            if (done || fail) begin
                got_done = done; got_fail = fail;
                break;
            end
            prev = scl_oe;
            idx++;
            @(negedge clk);
        end
        start_recovery = 1'b0;
        chk(got_done == ok && got_fail == !ok, "R6", "outcome done", got_done, ok);
        chk(idx == expi, poke ? "R8/R10" : "R5", "cycles to outcome", idx, expi);
        chk(pulses == k, "R4", "dummy pulses (R3 stop point)", pulses, k);
        chk(lowc == k*he, "R2", "SCL low cycles with SDA free", lowc, k*he);
        chk(stc == (ok ? he : 0), "R5", "Start hold cycles", stc, ok ? he : 0);
        chk(tlc == (ok ? he : 0), "R5", "tail cycles", tlc, ok ? he : 0);
        if (str) chk(got_fail, "R9", "held SCL blocks release", got_fail, 1);
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", done, 0);
        if (!ok) begin
            repeat (3) @(negedge clk);
            chk(fail && !scl_oe && !sda_oe, "R7", "fail sticky, lines free", fail, 1);
        end
        stretch = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe && !done && !fail, "R1", "reset outputs",
            {scl_oe, sda_oe, done, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_oe && !sda_oe && !done && !fail, "R1", "idle after reset",
            {scl_oe, sda_oe, done, fail}, 0);
        run_attempt(2, 0, 1'b0, 1'b0);   // R3 already released: one pulse
        run_attempt(1, 9, 1'b0, 1'b0);   // R4 release on last allowed pulse
        run_attempt(1, 10, 1'b0, 1'b0);  // R7 never released in time
        run_attempt(3, 2, 1'b0, 1'b0);   // R7 fail cleared by this request
        run_attempt(2, 1, 1'b1, 1'b0);   // R9 SCL held by slave
        run_attempt(0, 3, 1'b0, 1'b0);   // R2 zero half-period acts as one
        run_attempt(2, 5, 1'b0, 1'b1);   // R8 R10 request and period change mid-run
        for (int i = 0; i < 16; i++) begin
            run_attempt(int'($urandom % 5) + 1, int'($urandom % 12),
                        ($urandom % 6) == 0, ($urandom % 2) == 1);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule